// File: doc/BRIEF.md
# Memory Interface Training Step Sequencer

This block drives the bring-up of a memory interface. Software writes a control word that selects which bring-up and training steps are wanted and sets a start bit in the same write. The sequencer then walks a fixed list of thirteen steps. It hands each selected step to an external step engine with a one-cycle start pulse and a step index, and it waits for that engine to answer with done or fail before it looks at the next step.

A status register collects the outcome. It holds a done flag for each step that has one, an overall done flag, a mirrored set of error flags 16 bits higher, a 3-bit failure code, and the live state of the address/command PLL lock input. Software polls the overall done bit and every done bit it asked for, then inspects the error bits. Three bypass bits mark the PLL, delay-line and impedance steps complete without running them. A fourth bypass bit skips the whole sequence. A training configuration register supplies the rank selection and gate-training mode to the step engine.

Top module: `phy_train_seq`

## Requirements
- R1: The register port has three word addresses: 0 control, 1 status, 2 training configuration. Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled. Configuration keeps only bits 5:4 (training rank), bit 6 (gate training uses the multi-purpose register) and bits 27:24 (rank enable), and drives them to `cfg_rank`, `cfg_gate_mpr` and `cfg_rank_en`. Other configuration bits read as zero. Writes to status have no effect.
- R2: Writing the control register while idle stores bits 1, 4 to 15 and 28 to 31. All other bits, including bit 0, read back as zero. A write with bit 0 set also starts a run.
- R3: Steps are issued in this fixed order, shown as index(request bit): 0 PHY reset(6), 1 PLL init(4), 2 impedance calibration(1), 3 delay-line calibration(5), 4 DRAM reset(7), 5 DRAM init(8), 6 write leveling(9), 7 read gate training(10), 8 leveling adjust(11), 9 read deskew(12), 10 write deskew(13), 11 read eye(14), 12 write eye(15). Each step is issued as a one-cycle `step_start` with `step_idx` held until the step engine answers. No further step starts before `step_done` or `step_fail` arrives.
- R4: A step whose request bit is clear is never issued, and its done and error flags stay clear.
- R5: On `step_done`, the step's status done flag is set. The flag positions are: PLL init 1, delay-line calibration 2, impedance calibration 3, DRAM init 4, write leveling 5, gate training 6, leveling adjust 7, read deskew 8, write deskew 9, read eye 10, write eye 11. PHY reset and DRAM reset have no flag.
- R6: Control bits 28, 29 and 30 bypass PLL init, delay-line calibration and impedance calibration respectively. A requested step that is bypassed is not issued, but its done flag is set.
- R7: A start with control bit 31 set issues no step. Status then reads only the overall done bit, plus bit 31.
- R8: On `step_fail`, the sequencer sets status bit 16 and, for steps that have a flag, the flag position plus 16. It copies `step_code` into bits 30:28, abandons the remaining steps and sets the overall done bit 0.
- R9: Bit 0 is set once every requested step has completed. This includes a start that requests no step at all.
- R10: A start clears status bits 30:0. Bit 31 always shows `pll_lock`.
- R11: While a run is in progress, a control write, with or without bit 0, changes neither the running sequence nor the stored control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| step_start | output | 1 | One-cycle pulse starting a step |
| step_idx | output | 4 | Index of the step being run |
| step_done | input | 1 | Step engine reports success |
| step_fail | input | 1 | Step engine reports failure |
| step_code | input | 3 | Failure code sampled with `step_fail` |
| pll_lock | input | 1 | Address/command PLL lock state |
| cfg_rank | output | 2 | Rank used for deskew and eye training |
| cfg_gate_mpr | output | 1 | Gate training uses the multi-purpose register |
| cfg_rank_en | output | 4 | Rank enable for training |

## Verification
The assertions assume the step engine raises `step_done` or `step_fail` only while a step is outstanding, and holds each for a single cycle. They also assume at most one step fails per run. The bench's engine model keeps to this: it answers once for each start pulse it sees and then drops the response. Register strobes are driven away from the clock edge, one access at a time. The only control write issued during a run is the deliberate one used to check that such writes are ignored.

// File: rtl/ptseq_pkg.sv
package ptseq_pkg;

  localparam int NUM_STEPS = 13;
  localparam int IDX_W     = $clog2(NUM_STEPS + 1);
  localparam int FLAG_W    = 12;
  localparam int ERR_OFS   = 16;
  localparam int CODE_LSB  = 28;
  localparam int CODE_W    = 3;
  localparam int CTL_GO    = 0;
  localparam int CTL_SKIP  = 31;

  localparam logic [31:0] CTL_KEEP = 32'hF000_FFF2;
  localparam logic [31:0] CFG_KEEP = 32'h0F00_0070;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CFG  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SCAN = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  // control bit that requests step s
  function automatic int req_pos(input int s);
    case (s)
      0:       return 6;
      1:       return 4;
      2:       return 1;
      3:       return 5;
      default: return s + 3;
    endcase
  endfunction

  // status done-flag position of step s, 0 when the step has none
  function automatic int flag_pos(input int s);
    case (s)
      0, 4:    return 0;
      1:       return 1;
      2:       return 3;
      3:       return 2;
      default: return s - 1;
    endcase
  endfunction

  // control bypass bit of step s, 0 when the step cannot be bypassed
  function automatic int skip_pos(input int s);
    case (s)
      1:       return 28;
      2:       return 30;
      3:       return 29;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ptseq_step_map.sv
module ptseq_step_map
  import ptseq_pkg::*;
#(
  parameter int STEPS = NUM_STEPS
) (
  input  logic [31:0]                   ctl_word,
  output logic [STEPS-1:0]              run_vec,
  output logic [STEPS-1:0]              pass_vec,
  output logic [STEPS-1:0][FLAG_W-1:0]  flag_sel
);

  logic [STEPS-1:0] want;
  logic [STEPS-1:0] bypass;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    localparam int RP = req_pos(g);
    localparam int SP = skip_pos(g);
    localparam int FP = flag_pos(g);

    assign want[g] = ctl_word[RP];

    if (SP != 0) begin : g_byp
      assign bypass[g] = ctl_word[SP];
    end else begin : g_nobyp
      assign bypass[g] = 1'b0;
    end

    if (FP != 0) begin : g_flag
      assign flag_sel[g] = FLAG_W'(1) << FP;
    end else begin : g_noflag
      assign flag_sel[g] = '0;
    end

    assign run_vec[g]  = want[g] & ~bypass[g];
    assign pass_vec[g] = want[g] &  bypass[g];
  end

  // bits consumed elsewhere or reserved
  logic unused_ctl;
  assign unused_ctl = ^{ctl_word[CTL_GO], ctl_word[3:2], ctl_word[27:16], ctl_word[CTL_SKIP]};

endmodule

// File: rtl/ptseq_fsm.sv
module ptseq_fsm
  import ptseq_pkg::*;
#(
  parameter int STEPS = NUM_STEPS,
  parameter int IW    = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_skip,
  input  logic [STEPS-1:0] run_vec,
  input  logic [STEPS-1:0] pass_vec,
  input  logic             step_done,
  input  logic             step_fail,
  output logic             step_start,
  output logic [IW-1:0]    step_idx,
  output logic             busy,
  output logic             mark_ok,
  output logic             mark_err,
  output logic             finish
);

  sq_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          start_q, start_d;
  logic          at_end;
  logic          run_cur, pass_cur;

  assign at_end = (idx_q == IW'(STEPS));

  always_comb begin
    run_cur  = 1'b0;
    pass_cur = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if (idx_q == IW'(i)) begin
        run_cur  = run_vec[i];
        pass_cur = pass_vec[i];
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    start_d  = 1'b0;
    mark_ok  = 1'b0;
    mark_err = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (go) begin
          if (go_skip) begin
            finish = 1'b1;
          end else begin
            idx_d   = '0;
            state_d = SQ_SCAN;
          end
        end
      end
      SQ_SCAN: begin
        if (at_end) begin
          finish  = 1'b1;
          state_d = SQ_IDLE;
        end else if (run_cur) begin
          start_d = 1'b1;
          state_d = SQ_WAIT;
        end else begin
          mark_ok = pass_cur;
          idx_d   = idx_q + 1'b1;
        end
      end
      SQ_WAIT: begin
        if (step_fail) begin
          mark_err = 1'b1;
          finish   = 1'b1;
          state_d  = SQ_IDLE;
        end else if (step_done) begin
          mark_ok = 1'b1;
          idx_d   = idx_q + 1'b1;
          state_d = SQ_SCAN;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  assign step_start = start_q;
  assign step_idx   = idx_q;
  assign busy       = (state_q != SQ_IDLE);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |=> !step_start); // R3
  AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_done && !step_fail && step_start) |=> $stable(step_idx)); // R3
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (state_q == SQ_IDLE)); // R11
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> (step_idx < IW'(STEPS))); // R3

endmodule

// File: rtl/ptseq_regs.sv
module ptseq_regs
  import ptseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              mark_ok,
  input  logic              mark_err,
  input  logic              finish,
  input  logic [FLAG_W-1:0] flag_cur,
  input  logic [CODE_W-1:0] step_code,
  input  logic              pll_lock,
  output logic              go,
  output logic              go_skip,
  output logic [31:0]       ctl_word,
  output logic [1:0]        cfg_rank,
  output logic              cfg_gate_mpr,
  output logic [3:0]        cfg_rank_en
);

  logic [31:0] ctl_q, ctl_d;
  logic [31:0] cfg_q, cfg_d;
  logic [30:0] stat_q, stat_d;
  logic [31:0] rdata_q, rdata_d;
  logic        ctl_we, cfg_we;
  logic [31:0] rd_mux;

  assign ctl_we  = reg_wr && (reg_addr == ADDR_W'(A_CTRL)) && !busy;
  assign cfg_we  = reg_wr && (reg_addr == ADDR_W'(A_CFG));
  assign go      = ctl_we && reg_wdata[CTL_GO];
  assign go_skip = reg_wdata[CTL_SKIP];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = reg_wdata & CTL_KEEP;
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = reg_wdata & CFG_KEEP;
  end

  always_comb begin
    stat_d = go ? '0 : stat_q;
    if (mark_ok) stat_d[FLAG_W-1:0] = stat_d[FLAG_W-1:0] | flag_cur;
    if (mark_err) begin
      stat_d[ERR_OFS +: FLAG_W]       = stat_d[ERR_OFS +: FLAG_W] | flag_cur;
      stat_d[ERR_OFS]                 = 1'b1;
      stat_d[CODE_LSB +: CODE_W]      = step_code;
    end
    if (finish) stat_d[0] = 1'b1;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(A_CTRL): rd_mux = ctl_q;
      ADDR_W'(A_STAT): rd_mux = {pll_lock, stat_q};
      ADDR_W'(A_CFG):  rd_mux = cfg_q;
      default:         rd_mux = '0;
    endcase
    rdata_d = reg_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cfg_q   <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctl_q   <= ctl_d;
      cfg_q   <= cfg_d;
      stat_q  <= stat_d;
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata    = rdata_q;
  assign ctl_word     = ctl_q;
  assign cfg_rank     = cfg_q[5:4];
  assign cfg_gate_mpr = cfg_q[6];
  assign cfg_rank_en  = cfg_q[27:24];

  AST_CLEAR_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (stat_q[30:1] == '0)); // R10
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[ERR_OFS] |-> stat_q[0]); // R8
  AST_ONE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q[ERR_OFS+FLAG_W-1:ERR_OFS+1])); // R8
  AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_q)); // R11

endmodule

// File: rtl/phy_train_seq.sv
module phy_train_seq
  import ptseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              step_start,
  output logic [IDX_W-1:0]  step_idx,
  input  logic              step_done,
  input  logic              step_fail,
  input  logic [CODE_W-1:0] step_code,
  input  logic              pll_lock,
  output logic [1:0]        cfg_rank,
  output logic              cfg_gate_mpr,
  output logic [3:0]        cfg_rank_en
);

  localparam int STEPS = NUM_STEPS;

  logic                          go, go_skip, busy;
  logic                          mark_ok, mark_err, finish;
  logic [31:0]                   ctl_word;
  logic [STEPS-1:0]              run_vec, pass_vec;
  logic [STEPS-1:0][FLAG_W-1:0]  flag_sel;
  logic [FLAG_W-1:0]             flag_cur;

  always_comb begin
    flag_cur = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (step_idx == IDX_W'(i)) flag_cur = flag_sel[i];
    end
  end

  ptseq_step_map #(.STEPS(STEPS)) u_map (
    .ctl_word (ctl_word),
    .run_vec  (run_vec),
    .pass_vec (pass_vec),
    .flag_sel (flag_sel)
  );

  ptseq_fsm #(.STEPS(STEPS), .IW(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_skip    (go_skip),
    .run_vec    (run_vec),
    .pass_vec   (pass_vec),
    .step_done  (step_done),
    .step_fail  (step_fail),
    .step_start (step_start),
    .step_idx   (step_idx),
    .busy       (busy),
    .mark_ok    (mark_ok),
    .mark_err   (mark_err),
    .finish     (finish)
  );

  ptseq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .busy         (busy),
    .mark_ok      (mark_ok),
    .mark_err     (mark_err),
    .finish       (finish),
    .flag_cur     (flag_cur),
    .step_code    (step_code),
    .pll_lock     (pll_lock),
    .go           (go),
    .go_skip      (go_skip),
    .ctl_word     (ctl_word),
    .cfg_rank     (cfg_rank),
    .cfg_gate_mpr (cfg_gate_mpr),
    .cfg_rank_en  (cfg_rank_en)
  );

endmodule

// File: tb/phy_train_seq_bench.sv
module phy_train_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        step_start;
  logic [3:0]  step_idx;
  logic        step_done = 1'b0, step_fail = 1'b0;
  logic [2:0]  step_code = '0;
  logic        pll_lock = 1'b0;
  logic [1:0]  cfg_rank;
  logic        cfg_gate_mpr;
  logic [3:0]  cfg_rank_en;

  int n_chk = 0, n_bad = 0;
  bit over = 0;

  // step tables from the requirements (R3, R5, R6)
  int req_tab [13] = '{6, 4, 1, 5, 7, 8, 9, 10, 11, 12, 13, 14, 15};
  int flg_tab [13] = '{0, 1, 3, 2, 0, 4, 5, 6, 7, 8, 9, 10, 11};
  int byp_tab [13] = '{0, 28, 30, 29, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  int exp_q[$];
  int lat = 2;
  int fail_at = -1;
  logic [2:0] code_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_train_seq #(.ADDR_W(AW)) u_phy_train_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .step_start(step_start), .step_idx(step_idx), .step_done(step_done),
    .step_fail(step_fail), .step_code(step_code), .pll_lock(pll_lock),
    .cfg_rank(cfg_rank), .cfg_gate_mpr(cfg_gate_mpr), .cfg_rank_en(cfg_rank_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!over) begin
      over = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_read(1, v);
      if (v[0]) break;
    end
  endtask

  // driver: pushes the expected step list and returns the expected status
  task automatic plan_run(input logic [31:0] ctl, input int fidx, input logic [2:0] code,
                          output logic [31:0] est);
    bit stop = 0;
    est = '0;
    fail_at = fidx;
    code_val = code;
    if (!ctl[31]) begin
      for (int s = 0; s < 13; s++) begin
        if (stop || !ctl[req_tab[s]]) continue;
        if (byp_tab[s] != 0 && ctl[byp_tab[s]]) begin
          if (flg_tab[s] != 0) est[flg_tab[s]] = 1'b1;
          continue;
        end
        exp_q.push_back(s);
        if (s == fidx) begin
          est[16] = 1'b1;
          if (flg_tab[s] != 0) est[flg_tab[s] + 16] = 1'b1;
          est[30:28] = code;
          stop = 1;
        end else if (flg_tab[s] != 0) begin
          est[flg_tab[s]] = 1'b1;
        end
      end
    end
    est[0] = 1'b1;
  endtask

  task automatic run_check(input logic [31:0] ctl, input int fidx, input logic [2:0] code,
                           input string tag);
    logic [31:0] est, v;
    plan_run(ctl, fidx, code, est);
    reg_write(0, ctl | 32'h1);
    wait_done();
    reg_read(1, v);
    est[31] = pll_lock;
    chk({tag, " status"}, v, est);
    chk({tag, " R3 all expected steps issued"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  // monitor / step engine model: pops and compares each issued step
  initial begin
    forever begin
      @(negedge clk);
      if (step_start) begin
        int e = -1;
        if (exp_q.size() != 0) e = exp_q.pop_front();
        chk("R3 R4 step order", 32'(step_idx), 32'(e));
        repeat (lat) @(negedge clk);
        chk("R3 index held", 32'(step_idx), 32'(e));
        if (int'(step_idx) == fail_at) begin
          step_fail = 1'b1; step_code = code_val;
        end else begin
          step_done = 1'b1;
        end
        @(negedge clk);
        step_done = 1'b0; step_fail = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] v, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R1
    chk("R3 reset step_start", 32'(step_start), 0);
    reg_read(0, v); chk("R2 reset control", v, 0);
    reg_read(1, v); chk("R10 reset status", v, 0);
    reg_read(2, v); chk("R1 reset config", v, 0);

    // configuration register, R1
    reg_write(2, 32'hFFFF_FFFF);
    reg_read(2, v); chk("R1 config mask", v, 32'h0F00_0070);
    chk("R1 cfg fields", {25'd0, cfg_gate_mpr, cfg_rank_en, cfg_rank}, {25'd0, 1'b1, 4'hF, 2'd3});
    reg_write(2, 32'h0200_0020);
    reg_read(2, v); chk("R1 config readback", v, 32'h0200_0020);
    chk("R1 cfg fields 2", {25'd0, cfg_gate_mpr, cfg_rank_en, cfg_rank}, {25'd0, 1'b0, 4'h2, 2'd2});

    // control store without start, R2
    reg_write(0, 32'hFFFF_FFFE);
    reg_read(0, v); chk("R2 control mask", v, 32'hF000_FFF2);
    reg_read(1, v); chk("R2 no start without bit0", v, 0);

    // full run, R3 R5 R9 R10
    pll_lock = 1'b1;
    run_check(32'h0000_FFF2, -1, 3'd0, "R5 R9 full");
    reg_read(1, v); chk("R5 full flags literal", v, 32'h8000_0FFF);

    // sparse subset, R4
    run_check(32'h0000_1380, -1, 3'd0, "R4 subset");

    // bypass of pll/dcal/zcal plus phy reset, R6
    run_check(32'h7000_0072, -1, 3'd0, "R6 bypass");

    // empty request, R9
    run_check(32'h0000_0000, -1, 3'd0, "R9 empty");

    // failure at write leveling, R8
    lat = 4;
    run_check(32'h0000_FFF2, 6, 3'd5, "R8 fail wl");

    // failure at phy reset (no flag), R8
    pll_lock = 1'b0;
    run_check(32'h0000_FFF2, 0, 3'd2, "R8 fail phyrst");

    // bypass all clears previous error, R7 R10
    run_check(32'h8000_FFF2, -1, 3'd0, "R7 R10 skip all");

    // status write ignored, R1
    reg_read(1, prev);
    reg_write(1, 32'hFFFF_FFFF);
    reg_read(1, v); chk("R1 status read only", v, prev);

    // writes during a run are ignored, R11
    begin
      logic [31:0] est;
      lat = 30;
      plan_run(32'h0000_7F80, -1, 3'd0, est);
      reg_write(0, 32'h0000_7F81);
      repeat (12) @(negedge clk);
      reg_write(0, 32'h8000_0001);
      reg_write(0, 32'h0000_0002);
      reg_read(0, v); chk("R11 control frozen", v, 32'h0000_7F80);
      wait_done();
      reg_read(1, v); est[31] = pll_lock;
      chk("R11 run unaffected", v, est);
      chk("R11 all steps issued", 32'(exp_q.size()), 0);
      exp_q.delete();
    end

    // pll lock tracking, R10
    pll_lock = 1'b1;
    reg_read(1, v); chk("R10 lock bit", 32'(v[31]), 1);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule